// File: doc/BRIEF.md
# Serial Configuration Word Loader with Four Addressed Holding Registers

This block accepts configuration words on a three-wire serial link made of a serial clock, a data line and a load strobe. All three wires are brought into the system clock domain through synchronizer chains, and the block detects their rising edges there. On each rising edge of the serial clock, the data bit moves into a 24-bit shift register, most significant bit first. When the load strobe rises, the two lowest bits of the shift register act as an address. The upper 22 bits are written into the holding register that the address picks. Each holding register drives its payload onto its own output bus and pulses an update strobe for one system clock when its value is rewritten.

A small controller sequences the transfer. Its states are **ST_SHIFT**, **ST_XFER** and **ST_HOLD**:
- **ST_SHIFT** accepts serial clock edges. A detected load rise moves it to ST_XFER.
- **ST_XFER** lasts one cycle and writes the addressed register. It always moves to ST_HOLD.
- **ST_HOLD** waits until the synchronized load level is low again, then returns to ST_SHIFT.

A combinational read-back port selects one holding register by index for test.

Top module: `serial_cfg_latches`

## Requirements
- R1: After reset, all four holding registers read zero and no update strobe is high.
- R2: Data is taken on rising serial clock edges, most significant bit first. The stored payload equals bits 23..2 of the word that was shifted in.
- R3: Shift register bits 1..0 select the destination: 00 writes register 0, 01 writes register 1, 10 writes register 2 and 11 writes register 3.
- R4: A transfer leaves the three registers it does not address unchanged.
- R5: A rising load strobe makes exactly one update strobe pulse, that of the addressed register. The pulse lasts one system cycle and coincides with the new contents. It is first visible on the fourth falling system clock edge after the load input rises between clock edges.
- R6: Serial clock edges that occur while the load strobe is high do not alter the shift register.
- R7: If more or fewer than 24 bits are shifted before a load, the transfer uses the 24 most recently shifted bit positions, and no error is raised.
- R8: The read-back output shows the payload of the register whose index is on the read select input.
- R9: Reset clears the shift register. A load after only two shifted ones writes payload zero into register 3.
- R10: Holding the load strobe high for many cycles produces only one transfer. The controller passes from ST_XFER to ST_HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Load strobe; its rising edge starts a transfer |
| rd_sel | input | 2 | Read-back register index |
| latch_q | output | 4x22 | Payloads of the four holding registers, index 0 in the low slice |
| rd_data | output | 22 | Payload of the register picked by rd_sel |
| upd_stb | output | 4 | One-cycle update strobe for each register |

## Verification
- **Shift timing.** A serial bit lands in the shift register two system edges after its serial clock edge is sampled, because of the synchronizer and the edge detector. The bench holds data for several cycles around each serial clock edge, so sampling-phase differences do not matter.
- **Transfer timing.** Register contents and the update strobe change on the third system edge after the load level is first sampled. The bench therefore raises load just after a falling edge and samples on later falling edges. It requires the strobe on exactly the fourth of those edges and counts strobe cycles over a twelve-cycle window.
- **Register and read-back checks.** Register contents and read-back values are compared only after the window closes and load has dropped.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_XFER  = 2'd1,
        ST_HOLD  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scl_shift.sv
module scl_shift #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[WIDTH-2:0], din};
    end
endmodule

// File: rtl/scl_latch_bank.sv
module scl_latch_bank #(
    parameter int N     = 4,
    parameter int PW    = 22,
    parameter int SW    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SW-1:0]        wr_sel,
    input  logic [PW-1:0]        wr_data,
    output logic [N-1:0][PW-1:0] q,
    output logic [N-1:0]         stb
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_reg
            logic hit;
            assign hit = wr_en && (wr_sel == SW'(i));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q[i]   <= '0;
                    stb[i] <= 1'b0;
                end else begin
                    stb[i] <= hit;
                    if (hit) q[i] <= wr_data;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/serial_cfg_latches.sv
module serial_cfg_latches
    import scl_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CTRL_W      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PAY_W      = WORD_W - CTRL_W,
    localparam int NUM_LATCH  = 1 << CTRL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ser_clk,
    input  logic                           ser_data,
    input  logic                           ser_load,
    input  logic [CTRL_W-1:0]              rd_sel,
    output logic [NUM_LATCH-1:0][PAY_W-1:0] latch_q,
    output logic [PAY_W-1:0]               rd_data,
    output logic [NUM_LATCH-1:0]           upd_stb
);
    logic sclk_lvl, data_lvl, load_lvl;
    logic sclk_prev, load_prev;
    logic sclk_rise, load_rise;
    logic shift_en, wr_en;
    logic [WORD_W-1:0] shift_q;
    xfer_state_e state_q, state_d;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync_clk  (.clk(clk), .rst_n(rst_n), .d(ser_clk),  .q(sclk_lvl));
    scl_sync #(.STAGES(SYNC_STAGES)) u_sync_data (.clk(clk), .rst_n(rst_n), .d(ser_data), .q(data_lvl));
    scl_sync #(.STAGES(SYNC_STAGES)) u_sync_load (.clk(clk), .rst_n(rst_n), .d(ser_load), .q(load_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            load_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_lvl;
            load_prev <= load_lvl;
        end
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign load_rise = load_lvl & ~load_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHIFT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: if (load_rise) state_d = ST_XFER;
            ST_XFER:                 state_d = ST_HOLD;
            ST_HOLD:  if (!load_lvl) state_d = ST_SHIFT;
            default:                 state_d = ST_SHIFT;
        endcase
    end

    // controller outputs
    always_comb begin
        shift_en = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            ST_SHIFT: shift_en = sclk_rise && !load_lvl;
            ST_XFER:  wr_en    = 1'b1;
            ST_HOLD:  ;
            default:  ;
        endcase
    end

    scl_shift #(.WIDTH(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .din(data_lvl), .q(shift_q)
    );

    scl_latch_bank #(.N(NUM_LATCH), .PW(PAY_W), .SW(CTRL_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_sel(shift_q[CTRL_W-1:0]), .wr_data(shift_q[WORD_W-1:CTRL_W]),
        .q(latch_q), .stb(upd_stb)
    );

    assign rd_data = latch_q[rd_sel];
endmodule

// File: rtl/scl_checker.sv
module scl_checker
    import scl_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int PAY_W     = 22,
    parameter int NUM_LATCH = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input xfer_state_e                     state_q,
    input logic [WORD_W-1:0]               shift_q,
    input logic [NUM_LATCH-1:0]            upd_stb,
    input logic [NUM_LATCH-1:0][PAY_W-1:0] latch_q
);
    assert_stb_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd_stb));

    assert_stb_from_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd_stb) |-> ($past(state_q) == ST_XFER));

    assert_xfer_writes_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> ($countones(upd_stb) == 1));

    assert_xfer_to_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> (state_q == ST_HOLD));

    assert_shift_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SHIFT) |=> $stable(shift_q));

    generate
        for (genvar i = 0; i < NUM_LATCH; i++) begin : g_chk
            assert_unsel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_stb[i] |-> $stable(latch_q[i]));
        end
    endgenerate
endmodule

bind serial_cfg_latches scl_checker #(
    .WORD_W(WORD_W), .PAY_W(PAY_W), .NUM_LATCH(NUM_LATCH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .shift_q(shift_q),
    .upd_stb(upd_stb), .latch_q(latch_q)
);

// File: tb/tb_serial_cfg_latches.sv
module tb_serial_cfg_latches;
    localparam int WW = 24;
    localparam int PW = 22;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [NL-1:0][PW-1:0] latch_q;
    logic [PW-1:0] rd_data;
    logic [NL-1:0] upd_stb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [WW-1:0] sr_m = '0;
    logic [PW-1:0] exp_q [NL];

    always #10 clk = ~clk;

    serial_cfg_latches dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .rd_sel(rd_sel), .latch_q(latch_q),
        .rd_data(rd_data), .upd_stb(upd_stb)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] model_shift(input logic [WW-1:0] s, input logic b);
        return {s[WW-2:0], b};
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        @(negedge clk);
        sr_m = model_shift(sr_m, b);
    endtask

    task automatic send_bits(input logic [63:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
    endtask

    // R5 / R6 / R10: load pulse with strobe timing and counting
    task automatic do_load(input bit toggle_while_high);
        int cnt [NL];
        int first_c;
        logic [1:0] sel;
        sel = sr_m[1:0];
        exp_q[sel] = sr_m[WW-1:2];
        for (int i = 0; i < NL; i++) cnt[i] = 0;
        first_c = 0;
        @(negedge clk); ser_load = 1'b1;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            for (int i = 0; i < NL; i++) if (upd_stb[i]) begin
                cnt[i]++;
                if (first_c == 0) first_c = c;
            end
            if (toggle_while_high) begin
                ser_data = 1'b1;
                if (c == 3 || c == 7) ser_clk = 1'b1;
                if (c == 5 || c == 9) ser_clk = 1'b0;
            end
        end
        ser_load = 1'b0;
        for (int i = 0; i < NL; i++)
            chk(cnt[i] == (i == int'(sel) ? 1 : 0), "R5 strobe count", cnt[i], (i == int'(sel)) ? 1 : 0);
        chk(first_c == 4, "R5 strobe timing", first_c, 4);
        repeat (6) @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            chk(latch_q[i] == exp_q[i], (i == int'(sel)) ? "R2/R3 written register" : "R4 unselected register",
                latch_q[i], exp_q[i]);
            rd_sel = 2'(i);
            #1;
            chk(rd_data == exp_q[i], "R8 read-back", rd_data, exp_q[i]);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sr_m = '0;
        for (int i = 0; i < NL; i++) exp_q[i] = '0;
        @(negedge clk);
        for (int i = 0; i < NL; i++) chk(latch_q[i] == '0, "R1 reset register", latch_q[i], 0);
        chk(upd_stb == '0, "R1 reset strobe", upd_stb, 0);
    endtask

    initial begin
        logic [63:0] w;
        int n;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NL; i++) exp_q[i] = '0;
        @(negedge clk);
        do_reset();

        // R9: shift register cleared at reset
        send_bits(64'h3, 2);
        do_load(1'b0);
        chk(latch_q[3] == '0, "R9 cleared shift register", latch_q[3], 0);

        // R3: every address, directed payloads
        for (int a = 0; a < NL; a++) begin
            send_bits({40'd0, 22'h2A5A5A ^ 22'(a * 22'h111111), 2'(a)}, WW);
            do_load(1'b0);
        end

        // R6: clock edges while load is high are ignored; reload same word
        send_bits({40'd0, 22'h0F0F0F, 2'b10}, WW);
        do_load(1'b1);
        do_load(1'b0);
        chk(latch_q[2] == 22'h0F0F0F, "R6 shift held during load", latch_q[2], 22'h0F0F0F);

        // R7: too many and too few bits
        send_bits(64'h3F_ABCDE1, 30);
        do_load(1'b0);
        send_bits(64'h2C1, 10);
        do_load(1'b0);

        // random words with varied lengths
        for (int t = 0; t < 40; t++) begin
            w = {$urandom, $urandom};
            n = (t % 5 == 0) ? 18 + int'($urandom % 13) : WW;
            send_bits(w, n);
            do_load(1'b0);
        end

        // R1: reset mid-run clears populated registers
        do_reset();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule